// File: doc/BRIEF.md
# Selectable Audio Clock Multiplier Divider

This block derives one audio clock from a master timing clock. A 3-bit rate code picks the output as a multiple of the audio sample rate fs, from fs itself up to 512fs. The master clock is taken to run at 1024fs in standard mode and at 1536fs when the extended-rate enable is high. The extended mode is what makes the 192fs and 384fs settings reachable. A single fs-period phase counter, with a short sub-period counter beside it, yields every rate from terminal counts. The fs output is therefore always a true 50% left/right clock.

The divider is phase-locked to an external audio frame sync. The first rising edge of that sync after reset always realigns the chain. After that, the chain runs freely. It is pulled back only when a sync edge arrives further from the fs boundary than a programmable tolerance allows. While the PLL-lock flag is low, the tolerance is forced to zero, so that a start-up offset cannot persist. A rate or mode change waits for the next fs boundary, so no runt pulses are produced.

Top module: `aclk_gen`

## Requirements
- R1: While reset is active, and until the first fs boundary after reset, the audio clock is low and the output enable is low. The resync indicator is low during reset.
- R2: With extended mode off, the audio clock period is 1024/M master cycles. M is 1, 64, 128, 256 or 512 for rate codes 000, 001, 010, 100 and 110.
- R3: With extended mode on, the audio clock period is 1536/M master cycles. M is 1, 64, 128, 192, 256, 384 or 512 for codes 000, 001, 010, 011, 100, 101 and 110.
- R4: Rate code 111 drives the output enable low and holds the audio clock low.
- R5: Codes 011 and 101 while extended mode is off keep the output enable high and hold the audio clock low.
- R6: At code 000 the audio clock is high for exactly the first half of each fs period, with 50% duty.
- R7: At code 110 with extended mode on, the audio clock is high for one master cycle out of every three.
- R8: Every other active rate is high for the first half of its period.
- R9: A new rate code or extended-mode setting takes effect only at an fs boundary: a natural wrap of the phase counter, or a realignment.
- R10: The first frame sync rising edge after reset always realigns. The phase counter restarts at zero on that edge, and the resync indicator is high for exactly the following cycle.
- R11: A later sync rising edge is sampled with phase error e. The error is zero when the edge meets the last count of the fs period, positive when the edge is late and negative when it is early. If |e| exceeds the tolerance, the divider realigns and resync pulses. Otherwise nothing changes.
- R12: Window codes 000, 001, 010 and 011 give tolerances of 0, 1, 2 and 4 master cycles. Any code 1XX gives 16 cycles.
- R13: While PLL lock is low, the tolerance is 0 whatever the window code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master timing clock (1024fs or 1536fs) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Output rate code |
| ext_en | input | 1 | Extended-rate enable (1536fs master) |
| afs | input | 1 | Audio frame sync, synchronous to clk |
| pll_lock | input | 1 | Audio PLL locked flag |
| win_code | input | 3 | Realignment tolerance code |
| aclk | output | 1 | Audio clock |
| aclk_oe | output | 1 | Audio clock output enable |
| resync | output | 1 | One-cycle realignment indicator |

## Verification
The assertions check the invariants on every cycle. A disabled output carries no clock. A resync pulse lasts one cycle and always coincides with phase zero. The active rate changes only at phase zero. The extended 512fs clock never stays high for two cycles. Only the bench's scenarios can show the tolerance decisions at the window edges, the effect of the lock flag, the exact periods and duty counts per rate code, and the reserved-code behaviour. The bench's model follows each of these cycle by cycle.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [2:0] {
    RATE_X1   = 3'd0,
    RATE_X64  = 3'd1,
    RATE_X128 = 3'd2,
    RATE_X192 = 3'd3,
    RATE_X256 = 3'd4,
    RATE_X384 = 3'd5,
    RATE_X512 = 3'd6,
    RATE_OFF  = 3'd7
  } aclk_rate_e;

  // codes that need the 1536fs master clock
  function automatic logic needs_ext(input logic [2:0] code);
    return (code == RATE_X192) || (code == RATE_X384);
  endfunction

endpackage

// File: rtl/aclk_phase_ctr.sv
module aclk_phase_ctr
  import aclk_pkg::*;
#(
  parameter int STD_RATIO = 1024,
  parameter int EXT_RATIO = 1536,
  parameter int CNT_W     = 11,
  parameter int SUB_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             realign,
  input  logic [2:0]       sel_in,
  input  logic             ext_in,
  output logic [CNT_W-1:0] cnt,
  output logic [SUB_W-1:0] sub,
  output logic [SUB_W-1:0] sub_per,
  output logic [CNT_W-1:0] last_idx,
  output logic [2:0]       act_sel,
  output logic             act_ext
);

  localparam int S64  = STD_RATIO / 64;
  localparam int S128 = STD_RATIO / 128;
  localparam int S256 = STD_RATIO / 256;
  localparam int S512 = STD_RATIO / 512;
  localparam int E64  = EXT_RATIO / 64;
  localparam int E128 = EXT_RATIO / 128;
  localparam int E192 = EXT_RATIO / 192;
  localparam int E256 = EXT_RATIO / 256;
  localparam int E384 = EXT_RATIO / 384;
  localparam int E512 = EXT_RATIO / 512;

  logic [CNT_W-1:0] cnt_n;
  logic [SUB_W-1:0] sub_n;
  logic [2:0]       sel_n;
  logic             ext_n;
  logic             wrap;

  // sub-period length of the active rate
  always_comb begin
    unique case (act_sel)
      RATE_X64:  sub_per = act_ext ? SUB_W'(E64)  : SUB_W'(S64);
      RATE_X128: sub_per = act_ext ? SUB_W'(E128) : SUB_W'(S128);
      RATE_X192: sub_per = act_ext ? SUB_W'(E192) : SUB_W'(1);
      RATE_X256: sub_per = act_ext ? SUB_W'(E256) : SUB_W'(S256);
      RATE_X384: sub_per = act_ext ? SUB_W'(E384) : SUB_W'(1);
      RATE_X512: sub_per = act_ext ? SUB_W'(E512) : SUB_W'(S512);
      default:   sub_per = SUB_W'(1);
    endcase
  end

  assign last_idx = act_ext ? CNT_W'(EXT_RATIO - 1) : CNT_W'(STD_RATIO - 1);
  assign wrap     = realign || (cnt == last_idx);

  always_comb begin
    if (wrap) begin
      cnt_n = '0;
      sub_n = '0;
      sel_n = sel_in;
      ext_n = ext_in;
    end else begin
      cnt_n = cnt + 1'b1;
      sub_n = (sub == SUB_W'(sub_per - 1'b1)) ? '0 : sub + 1'b1;
      sel_n = act_sel;
      ext_n = act_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sub     <= '0;
      act_sel <= RATE_OFF;
      act_ext <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      sub     <= sub_n;
      act_sel <= sel_n;
      act_ext <= ext_n;
    end
  end

endmodule

// File: rtl/aclk_sync_win.sv
module aclk_sync_win #(
  parameter int CNT_W   = 11,
  parameter int TOL_C1  = 1,
  parameter int TOL_C2  = 2,
  parameter int TOL_C3  = 4,
  parameter int TOL_WID = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             afs,
  input  logic             lock,
  input  logic [2:0]       win_code,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] last_idx,
  output logic             realign,
  output logic             resync
);

  logic             afs_d;
  logic             aligned;
  logic             aligned_n;
  logic             rise;
  logic             in_win;
  logic [CNT_W:0]   tol;
  logic [CNT_W:0]   err_late;
  logic [CNT_W:0]   err_early;

  always_comb begin
    if (!lock) begin
      tol = '0;
    end else if (win_code[2]) begin
      tol = (CNT_W+1)'(TOL_WID);
    end else begin
      unique case (win_code[1:0])
        2'd1:    tol = (CNT_W+1)'(TOL_C1);
        2'd2:    tol = (CNT_W+1)'(TOL_C2);
        2'd3:    tol = (CNT_W+1)'(TOL_C3);
        default: tol = '0;
      endcase
    end
  end

  // distance of the sync edge from the fs boundary, both directions
  assign err_late  = (cnt == last_idx) ? '0 : {1'b0, cnt} + 1'b1;
  assign err_early = {1'b0, last_idx} + 1'b1 - err_late;

  assign rise      = afs && !afs_d;
  assign in_win    = (err_late <= tol) || (err_early <= tol);
  assign realign   = rise && (!aligned || !in_win);
  assign aligned_n = aligned || rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      afs_d   <= 1'b0;
      aligned <= 1'b0;
      resync  <= 1'b0;
    end else begin
      afs_d   <= afs;
      aligned <= aligned_n;
      resync  <= realign;
    end
  end

endmodule

// File: rtl/aclk_out_dec.sv
module aclk_out_dec
  import aclk_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int SUB_W = 5
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [SUB_W-1:0] sub,
  input  logic [SUB_W-1:0] sub_per,
  input  logic [CNT_W-1:0] last_idx,
  input  logic [2:0]       act_sel,
  input  logic             act_ext,
  output logic             clk_d,
  output logic             oe_d
);

  logic disabled;
  logic reserved;
  logic fs_hi;
  logic rate_hi;

  assign disabled = (act_sel == RATE_OFF);
  assign reserved = !act_ext && needs_ext(act_sel);
  // fs period length is last_idx+1 (even), half is (last_idx>>1)+1
  assign fs_hi    = (cnt <= (last_idx >> 1));
  // period 3 gives half 1: one high cycle of three
  assign rate_hi  = (sub < (sub_per >> 1));

  assign oe_d  = !disabled;
  assign clk_d = !disabled && !reserved &&
                 ((act_sel == RATE_X1) ? fs_hi : rate_hi);

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen #(
  parameter int STD_RATIO = 1024,
  parameter int EXT_RATIO = 1536,
  parameter int TOL_C1    = 1,
  parameter int TOL_C2    = 2,
  parameter int TOL_C3    = 4,
  parameter int TOL_WID   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       ext_en,
  input  logic       afs,
  input  logic       pll_lock,
  input  logic [2:0] win_code,
  output logic       aclk,
  output logic       aclk_oe,
  output logic       resync
);

  localparam int MAX_RATIO = (EXT_RATIO > STD_RATIO) ? EXT_RATIO : STD_RATIO;
  localparam int CNT_W     = $clog2(MAX_RATIO);
  localparam int SUB_W     = $clog2(MAX_RATIO / 64 + 1);

  logic             rst_s1;
  logic             rst_i;
  logic             realign;
  logic [CNT_W-1:0] fs_cnt;
  logic [SUB_W-1:0] sub_cnt;
  logic [SUB_W-1:0] sub_per;
  logic [CNT_W-1:0] last_idx;
  logic [2:0]       act_sel;
  logic             act_ext;
  logic             clk_d;
  logic             oe_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  aclk_phase_ctr #(
    .STD_RATIO(STD_RATIO), .EXT_RATIO(EXT_RATIO),
    .CNT_W(CNT_W), .SUB_W(SUB_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_i), .realign(realign),
    .sel_in(rate_sel), .ext_in(ext_en),
    .cnt(fs_cnt), .sub(sub_cnt), .sub_per(sub_per), .last_idx(last_idx),
    .act_sel(act_sel), .act_ext(act_ext)
  );

  aclk_sync_win #(
    .CNT_W(CNT_W), .TOL_C1(TOL_C1), .TOL_C2(TOL_C2),
    .TOL_C3(TOL_C3), .TOL_WID(TOL_WID)
  ) u_sync (
    .clk(clk), .rst_n(rst_i), .afs(afs), .lock(pll_lock),
    .win_code(win_code), .cnt(fs_cnt), .last_idx(last_idx),
    .realign(realign), .resync(resync)
  );

  aclk_out_dec #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_dec (
    .cnt(fs_cnt), .sub(sub_cnt), .sub_per(sub_per), .last_idx(last_idx),
    .act_sel(act_sel), .act_ext(act_ext), .clk_d(clk_d), .oe_d(oe_d)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      aclk    <= 1'b0;
      aclk_oe <= 1'b0;
    end else begin
      aclk    <= clk_d;
      aclk_oe <= oe_d;
    end
  end

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       aclk,
  input logic       aclk_oe,
  input logic       resync,
  input logic       cnt_zero,
  input logic [2:0] act_sel,
  input logic       act_ext
);

  assert_off_is_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !aclk_oe |-> !aclk);

  assert_resync_at_phase0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> cnt_zero);

  assert_resync_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  assert_rate_change_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_zero |-> ($stable(act_sel) && $stable(act_ext)));

  assert_third_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ext && act_sel == 3'd6 && aclk && !resync) |=> !aclk);

endmodule

bind aclk_gen aclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_i), .aclk(aclk), .aclk_oe(aclk_oe),
  .resync(resync), .cnt_zero(fs_cnt == '0),
  .act_sel(act_sel), .act_ext(act_ext)
);

// File: tb/aclk_gen_tb.sv
module aclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic       ext_en;
  logic       afs;
  logic       pll_lock;
  logic [2:0] win_code;
  logic       aclk;
  logic       aclk_oe;
  logic       resync;

  always #4 clk = ~clk;

  aclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_en(ext_en),
    .afs(afs), .pll_lock(pll_lock), .win_code(win_code),
    .aclk(aclk), .aclk_oe(aclk_oe), .resync(resync)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    do_cmp = 1'b0;

  // behavioural reference state
  int m_cnt, m_sel, m_ext, m_aligned, m_afs_d, m_s1, m_s2;
  bit e_clk, e_oe, e_rs;

  function automatic int mult_of(int s);
    case (s)
      0: return 1;   1: return 64;  2: return 128; 3: return 192;
      4: return 256; 5: return 384; 6: return 512;
      default: return 0;
    endcase
  endfunction

  function automatic int ratio_of(int x);
    return (x != 0) ? 1536 : 1024;
  endfunction

  function automatic int tol_of(bit lk, int w);
    if (!lk) return 0;
    if (w >= 4) return 16;
    case (w)
      1: return 1; 2: return 2; 3: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int p, e, per;
    bit rise, re;
    if (!rst_n) begin
      m_cnt = 0; m_sel = 7; m_ext = 0; m_aligned = 0; m_afs_d = 0;
      m_s1 = 0; m_s2 = 0; e_clk = 0; e_oe = 0; e_rs = 0;
    end else begin
      if (m_s2 != 0) begin
        p = ratio_of(m_ext);
        if (m_sel == 7) begin
          e_clk = 0; e_oe = 0;
        end else if (m_ext == 0 && (m_sel == 3 || m_sel == 5)) begin
          e_clk = 0; e_oe = 1;
        end else begin
          per = p / mult_of(m_sel);
          e_clk = (m_cnt % per) < (per / 2);
          e_oe = 1;
        end
        rise = afs && (m_afs_d == 0);
        e = (m_cnt + 1) % p;
        re = rise && ((m_aligned == 0) ||
             !((e <= tol_of(pll_lock, int'(win_code))) ||
               ((p - e) <= tol_of(pll_lock, int'(win_code)))));
        e_rs = re;
        if (rise) m_aligned = 1;
        m_afs_d = afs;
        if (re || m_cnt == p - 1) begin
          m_cnt = 0; m_sel = int'(rate_sel); m_ext = int'(ext_en);
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (do_cmp && rst_n) begin
      chk(cur_req, aclk, e_clk, "aclk");
      chk(cur_req, aclk_oe, e_oe, "aclk_oe");
      chk(cur_req, resync, e_rs, "resync");
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // frame sync edge with phase error off (0 = exactly on the boundary)
  task automatic pulse(int off, logic exp_re, string req);
    int p, target;
    p = ratio_of(m_ext);
    target = (((off - 1) % p) + p) % p;
    @(negedge clk);
    while (m_cnt != target) @(negedge clk);
    afs = 1'b1;
    @(negedge clk);
    afs = 1'b0;
    chk(req, resync, exp_re, "resync after sync edge");
    run(3);
  endtask

  task automatic count_high(int n, int exp, string req);
    int h;
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (aclk) h++;
    end
    checks++;
    if (h != exp) begin
      errors++;
      $display("FAIL %s high count actual %0d expected %0d", req, h, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rate_sel = 3'd0; ext_en = 1'b0; afs = 1'b0;
    pll_lock = 1'b0; win_code = 3'd0;
    run(3);
    chk("R1", aclk, 1'b0, "aclk in reset");
    chk("R1", aclk_oe, 1'b0, "oe in reset");
    chk("R1", resync, 1'b0, "resync in reset");
    rst_n = 1'b1;
    do_cmp = 1'b1;
    run(40);
    chk("R1", aclk_oe, 1'b0, "oe before first boundary");

    // first alignment, far from the boundary
    cur_req = "R10";
    pulse(300, 1'b1, "R10");
    cur_req = "R6";
    run(50);
    count_high(1024, 512, "R6");

    // lock low forces zero tolerance
    cur_req = "R13";
    win_code = 3'd3;
    pulse(2, 1'b1, "R13");
    pulse(0, 1'b0, "R13");

    // tolerance windows with lock
    pll_lock = 1'b1;
    cur_req = "R12";
    pulse(2, 1'b0, "R12");
    pulse(-4, 1'b0, "R12");
    cur_req = "R11";
    pulse(5, 1'b1, "R11");
    pulse(-5, 1'b1, "R11");
    cur_req = "R12";
    win_code = 3'd4;
    pulse(16, 1'b0, "R12");
    pulse(-17, 1'b1, "R12");
    win_code = 3'd1;
    pulse(1, 1'b0, "R12");
    pulse(2, 1'b1, "R12");
    win_code = 3'd2;
    pulse(-2, 1'b0, "R12");
    win_code = 3'd0;
    pulse(1, 1'b1, "R12");

    // rate change mid-period waits for the boundary
    cur_req = "R9";
    @(negedge clk);
    while (m_cnt != 100) @(negedge clk);
    rate_sel = 3'd1;
    run(2);
    chk("R9", aclk, 1'b1, "fs level held after code change");
    run(400);
    chk("R9", aclk, 1'b1, "fs level held until boundary");
    cur_req = "R2";
    run(2048);
    foreach (rate_sel[i]) begin end
    for (int s = 2; s <= 6; s += 2) begin
      rate_sel = 3'(s);
      cur_req = "R2";
      run(2048);
    end
    cur_req = "R8";
    rate_sel = 3'd4;
    run(2048);

    // reserved codes and disabled output
    cur_req = "R5";
    rate_sel = 3'd3;
    run(2100);
    chk("R5", aclk_oe, 1'b1, "oe with reserved code");
    count_high(200, 0, "R5");
    rate_sel = 3'd5;
    run(1100);
    count_high(200, 0, "R5");
    cur_req = "R4";
    rate_sel = 3'd7;
    run(1100);
    chk("R4", aclk_oe, 1'b0, "oe with off code");
    count_high(200, 0, "R4");

    // extended mode rates
    ext_en = 1'b1;
    for (int s = 0; s <= 5; s++) begin
      rate_sel = 3'(s);
      cur_req = (s == 0) ? "R6" : "R3";
      run(3100);
    end
    cur_req = "R7";
    rate_sel = 3'd6;
    run(1600);
    count_high(1536, 512, "R7");
    pll_lock = 1'b1;
    win_code = 3'd3;
    cur_req = "R11";
    pulse(3, 1'b0, "R11");
    pulse(-6, 1'b1, "R11");
    cur_req = "R7";
    run(200);

    do_cmp = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule